// File: doc/BRIEF.md
# Macroblock Coded-Data Output Sequencer

This block sits at the output of a video encoder and sends, for every macroblock, its side information and its coefficient stream over a byte-wide port. Each byte is tagged by a 4-bit mode code, and a strobe lets a downstream multiplexer capture the byte. Every event lasts a fixed number of clock cycles. Each coded sub-block is padded to a fixed cycle budget, so the receiver sees a stream with predictable timing.

A macroblock begins with a one-cycle start pulse. At that pulse the block latches the macroblock fields: group and macroblock numbers, the decision flags, the quantiser, both motion vector components, the coded block pattern and a dummy marker. It then walks the header events. For every coded block it fetches run/level pairs from a coefficient source through a request/valid handshake. At the end it rests in a final wait, which it shows by raising its ready output.

Top module: `mb_out_seq`

## Requirements
- R1: `mode` carries only these values: 0 group number, 1 macroblock number, 2 control byte, 3 quantiser, 4 horizontal vector, 5 vertical vector, 6 coded block pattern (block i in bit i), 7 sub-block index, 8 run count, 9 magnitude, 15 wait. Values 10 to 14 never appear.
- R2: `strobe` is high in a cycle exactly when `mode` is not 15 and `mode` and `data` held the same value in the previous cycle. It therefore rises one cycle after a new code appears and falls on the edge that changes the code.
- R3: While `mode` is 15, `strobe` is low.
- R4: The control byte carries `ctrl_flags` bits 3..0 in data bits 3..0. It carries `ctrl_flags[4]` (fast update) in bit 5 and `ctrl_flags[5]` (skipped frame) in bit 6. Bits 4 and 7 are 0.
- R5: One cycle after the accepted start pulse, the block shows a 2-cycle wait. It then shows these events for 2 cycles each, in this order: control byte, group number, macroblock number, coded block pattern, quantiser, horizontal vector, vertical vector.
- R6: When `dummy` was set at start, the control byte event is left out and the group number follows the initial wait.
- R7: With a zero coded block pattern, the final wait follows the vertical vector directly. Otherwise a 32-cycle wait follows, and then the coded blocks are sent in ascending block order.
- R8: A coded block shows its index (zero-extended) for 15 cycles. Then, for each pair, it shows the run for 2 cycles, the magnitude for 2 cycles and a 1-cycle wait. The last pair is the one fetched with `coef_last` high.
- R9: Each coded block, from its first index cycle up to the start of the next block or of the final wait, lasts exactly `SUB_BUDGET` (335) cycles, padded with wait cycles. This holds for 1 to 64 pairs.
- R10: `overflow` rises when a block's pairs overrun `SUB_BUDGET`, and no padding is added in that case. Once high it stays high until reset. It stays low for blocks of at most 64 pairs.
- R11: `ready` is high exactly in the final wait. A start pulse is accepted only there. Field inputs and start pulses that arrive while the block is busy do not affect the output sequence.
- R12: After reset, `mode` is 15, `data` is 0, `strobe` is low, `ready` is high, and `overflow` and `coef_req` are low.
- R13: A run/level pair is taken on a clock edge where `coef_req` and `coef_valid` are both high. `coef_req` is high in the last index cycle of a block and in each 1-cycle wait that follows a pair that is not the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start-of-macroblock pulse |
| dummy | input | 1 | Macroblock is a dummy (no control byte event) |
| gob_num | input | DW | Group number |
| mb_num | input | DW | Macroblock number |
| ctrl_flags | input | 6 | Decision flags: fixed, inter, filter, motion comp, fast update, skip |
| quant | input | DW | Quantiser value |
| mv_h | input | DW | Horizontal motion vector |
| mv_v | input | DW | Vertical motion vector |
| cbp | input | NBLK | Coded block pattern |
| coef_req | output | 1 | Requests the next run/level pair |
| coef_valid | input | 1 | The pair on the coefficient inputs is valid |
| coef_run | input | DW | Zero-run count |
| coef_mag | input | DW | Coefficient magnitude |
| coef_last | input | 1 | This pair is the last one of its block |
| mode | output | 4 | Mode code of the current byte |
| data | output | DW | Output byte |
| strobe | output | 1 | Capture strobe for the downstream multiplexer |
| ready | output | 1 | Final wait; a new start is accepted |
| overflow | output | 1 | Sticky sub-block budget overrun |

## Verification
The bench builds the block with its default parameters: 8-bit data, six blocks, 15-cycle index event, 32-cycle gap and a 335-cycle sub-block budget. With these values, 64 pairs fill the budget to the last cycle, so the case where no padding cycle is needed is reachable. A 65-pair block then brings the overflow path within reach. Random macroblocks vary the pattern, the dummy marker and the number of pairs per block, and directed ones cover an empty pattern, all flags set and a start pulse during a busy macroblock.

// File: rtl/mb_out_seq.sv
module mb_out_seq #(
  parameter int DW         = 8,
  parameter int NBLK       = 6,
  parameter int PRE_LEN    = 2,
  parameter int HDR_LEN    = 2,
  parameter int GAP_LEN    = 32,
  parameter int IDX_LEN    = 15,
  parameter int PAIR_LEN   = 2,
  parameter int SUB_BUDGET = 335
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            dummy,
  input  logic [DW-1:0]   gob_num,
  input  logic [DW-1:0]   mb_num,
  input  logic [5:0]      ctrl_flags,
  input  logic [DW-1:0]   quant,
  input  logic [DW-1:0]   mv_h,
  input  logic [DW-1:0]   mv_v,
  input  logic [NBLK-1:0] cbp,
  output logic            coef_req,
  input  logic            coef_valid,
  input  logic [DW-1:0]   coef_run,
  input  logic [DW-1:0]   coef_mag,
  input  logic            coef_last,
  output logic [3:0]      mode,
  output logic [DW-1:0]   data,
  output logic            strobe,
  output logic            ready,
  output logic            overflow
);
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int CW = $clog2(SUB_BUDGET + 1);
  localparam logic [CW-1:0] SB_END = CW'(SUB_BUDGET - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_W0, S_CTRL, S_GOB, S_MB, S_CBP, S_QNT, S_MVH, S_MVV,
    S_GAP, S_IDX, S_RUN, S_MAG, S_W1, S_PAD
  } st_t;

  st_t st, nst;
  logic [CW-1:0] cnt, ncnt, sbc;
  logic [BW-1:0] blk, nblk;
  logic [NBLK-1:0] rem, nrem, cbp_q;
  logic [DW-1:0] gob_q, mb_q, qnt_q, mvh_q, mvv_q, run_q, mag_q, ndata;
  logic [5:0] flg_q;
  logic dummy_q, last_q;

  function automatic int len_of(st_t s);
    case (s)
      S_W0:          len_of = PRE_LEN;
      S_GAP:         len_of = GAP_LEN;
      S_IDX:         len_of = IDX_LEN;
      S_RUN, S_MAG:  len_of = PAIR_LEN;
      S_CTRL, S_GOB, S_MB, S_CBP, S_QNT, S_MVH, S_MVV: len_of = HDR_LEN;
      default:       len_of = 1;
    endcase
  endfunction

  function automatic logic [3:0] code_of(st_t s);
    case (s)
      S_GOB:  code_of = 4'd0;
      S_MB:   code_of = 4'd1;
      S_CTRL: code_of = 4'd2;
      S_QNT:  code_of = 4'd3;
      S_MVH:  code_of = 4'd4;
      S_MVV:  code_of = 4'd5;
      S_CBP:  code_of = 4'd6;
      S_IDX:  code_of = 4'd7;
      S_RUN:  code_of = 4'd8;
      S_MAG:  code_of = 4'd9;
      default: code_of = 4'd15;
    endcase
  endfunction

  function automatic logic [BW-1:0] low_idx(input logic [NBLK-1:0] m);
    low_idx = '0;
    for (int i = NBLK - 1; i >= 0; i--) if (m[i]) low_idx = BW'(i);
  endfunction

  wire done      = (cnt == CW'(len_of(st) - 1));
  wire fetch     = coef_req && coef_valid;
  wire budget_up = (sbc >= SB_END);
  wire in_sub    = (st == S_IDX) || (st == S_RUN) || (st == S_MAG) || (st == S_W1);
  wire [BW-1:0]   first_blk = low_idx(rem);
  wire [NBLK-1:0] rem_clr   = rem & ~(NBLK'(1) << first_blk);
  wire st_t       after_sub = (rem != '0) ? S_IDX : S_IDLE;

  always_comb begin
    nst  = st;
    ncnt = cnt + 1'b1;
    nblk = blk;
    nrem = rem;
    case (st)
      S_IDLE: if (start) nst = S_W0;
      S_W0:   if (done) nst = dummy_q ? S_GOB : S_CTRL;
      S_CTRL: if (done) nst = S_GOB;
      S_GOB:  if (done) nst = S_MB;
      S_MB:   if (done) nst = S_CBP;
      S_CBP:  if (done) nst = S_QNT;
      S_QNT:  if (done) nst = S_MVH;
      S_MVH:  if (done) nst = S_MVV;
      S_MVV:  if (done) nst = (cbp_q != '0) ? S_GAP : S_IDLE;
      S_GAP:  if (done) nst = S_IDX;
      S_IDX:  if (done) begin
                if (fetch) nst = S_RUN;
                else ncnt = cnt;
              end
      S_RUN:  if (done) nst = S_MAG;
      S_MAG:  if (done) nst = S_W1;
      S_W1:   if (last_q) nst = budget_up ? after_sub : S_PAD;
              else if (fetch) nst = S_RUN;
              else ncnt = cnt;
      S_PAD:  if (budget_up) nst = after_sub;
      default: nst = S_IDLE;
    endcase
    if (nst != st || st == S_IDLE || st == S_PAD) ncnt = '0;
    if (nst == S_IDX && st != S_IDX) begin
      nblk = first_blk;
      nrem = rem_clr;
    end
  end

  always_comb begin
    case (nst)
      S_CTRL: ndata = DW'({1'b0, flg_q[5:4], 1'b0, flg_q[3:0]});
      S_GOB:  ndata = gob_q;
      S_MB:   ndata = mb_q;
      S_CBP:  ndata = DW'(cbp_q);
      S_QNT:  ndata = qnt_q;
      S_MVH:  ndata = mvh_q;
      S_MVV:  ndata = mvv_q;
      S_IDX:  ndata = DW'(nblk);
      S_RUN:  ndata = fetch ? coef_run : run_q;
      S_MAG:  ndata = mag_q;
      default: ndata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; sbc <= '0; blk <= '0; rem <= '0;
      mode <= 4'd15; data <= '0; strobe <= 1'b0; ready <= 1'b1;
      overflow <= 1'b0; coef_req <= 1'b0; last_q <= 1'b0;
      run_q <= '0; mag_q <= '0;
    end else begin
      st  <= nst;
      cnt <= ncnt;
      blk <= nblk;
      rem <= nrem;
      if (nst == S_IDX && st != S_IDX) sbc <= '0;
      else if (sbc != '1) sbc <= sbc + 1'b1;
      mode     <= code_of(nst);
      data     <= ndata;
      strobe   <= (mode != 4'd15) && (code_of(nst) == mode);
      ready    <= (nst == S_IDLE);
      coef_req <= (nst == S_IDX && ncnt == CW'(IDX_LEN - 1)) || (nst == S_W1 && !last_q);
      if (fetch) begin
        run_q  <= coef_run;
        mag_q  <= coef_mag;
        last_q <= coef_last;
      end
      if (in_sub && budget_up && !(st == S_W1 && last_q)) overflow <= 1'b1;
    end
    if (st == S_IDLE && start) begin
      gob_q <= gob_num; mb_q <= mb_num; flg_q <= ctrl_flags; qnt_q <= quant;
      mvh_q <= mv_h; mvv_q <= mv_v; cbp_q <= cbp; dummy_q <= dummy;
      if (!rst) rem <= cbp;
    end
  end

  assert_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
    !(mode inside {[4'd10:4'd14]}));
  assert_strobe_after_hold_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (mode == $past(mode)) && (data == $past(data)));
  assert_strobe_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> !strobe);
  assert_wait_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd15) |-> !strobe);
  assert_ready_in_wait_R11: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mode == 4'd15) && !coef_req);
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow);
  assert_req_in_wait_or_idx_R13: assert property (@(posedge clk) disable iff (rst)
    coef_req |-> (mode == 4'd7) || (mode == 4'd15));
endmodule

// File: tb/mb_out_seq_bench.sv
`timescale 1ns/1ps
module mb_out_seq_bench;
  localparam int NBLK = 6, BUDGET = 335, MAXT = 2300, MAXC = 6 * 70;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dummy = 1'b0;
  logic [7:0] gob_num = '0, mb_num = '0, quant = '0, mv_h = '0, mv_v = '0;
  logic [5:0] ctrl_flags = '0;
  logic [NBLK-1:0] cbp = '0;
  logic coef_valid = 1'b1, coef_last = 1'b0;
  logic [7:0] coef_run = '0, coef_mag = '0;
  logic coef_req, strobe, ready, overflow;
  logic [3:0] mode;
  logic [7:0] data;

  mb_out_seq u_mb_out_seq (
    .clk(clk), .rst(rst), .start(start), .dummy(dummy), .gob_num(gob_num),
    .mb_num(mb_num), .ctrl_flags(ctrl_flags), .quant(quant), .mv_h(mv_h),
    .mv_v(mv_v), .cbp(cbp), .coef_req(coef_req), .coef_valid(coef_valid),
    .coef_run(coef_run), .coef_mag(coef_mag), .coef_last(coef_last),
    .mode(mode), .data(data), .strobe(strobe), .ready(ready), .overflow(overflow));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int em[MAXT], ed[MAXT];
  int tl;
  int frun[MAXC], fmag[MAXC];
  bit flast[MAXC];
  int fn;
  int ncoef[NBLK];
  int od2, om2;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int m, input int d, input int n);
    for (int k = 0; k < n; k++) begin em[tl] = m; ed[tl] = d; tl++; end
  endtask

  function automatic int ctrl_byte(input logic [5:0] f);
    return {1'b0, f[5], f[4], 1'b0, f[3:0]};
  endfunction

  task automatic build();
    int s;
    tl = 0; fn = 0;
    push(15, 0, 2);
    if (!dummy) push(2, ctrl_byte(ctrl_flags), 2);
    push(0, gob_num, 2); push(1, mb_num, 2); push(6, cbp, 2);
    push(3, quant, 2); push(4, mv_h, 2); push(5, mv_v, 2);
    if (cbp != 0) begin
      push(15, 0, 32);
      for (int b = 0; b < NBLK; b++) if (cbp[b]) begin
        s = tl;
        push(7, b, 15);
        for (int k = 0; k < ncoef[b]; k++) begin
          frun[fn] = $urandom_range(0, 63);
          fmag[fn] = $urandom_range(1, 255);
          flast[fn] = (k == ncoef[b] - 1);
          push(8, frun[fn], 2); push(9, fmag[fn], 2); push(15, 0, 1);
          fn++;
        end
        if (BUDGET - (tl - s) > 0) push(15, 0, BUDGET - (tl - s));
      end
    end
  endtask

  task automatic run_mb(input string tag, input bit spurious, input bit expect_ovf);
    int fi, bad_md, bad_s2, bad_s3, bad_rdy, bad_ill, bad_gap, last7, prevm, prevd;
    int am, xm, as2, xs2;
    bit pend, exp_s;
    build();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    fi = 0; pend = 0; bad_md = 0; bad_s2 = 0; bad_s3 = 0; bad_rdy = 0; bad_ill = 0;
    bad_gap = 0; last7 = -1; prevm = 15; prevd = 0; am = 0; xm = 0; as2 = 0; xs2 = 0;
    for (int i = 0; i <= tl; i++) begin
      if (pend) fi++;
      if (fi < fn) begin
        coef_run = frun[fi][7:0]; coef_mag = fmag[fi][7:0]; coef_last = flast[fi];
      end
      pend = coef_req;
      if (mode inside {[4'd10:4'd14]}) bad_ill++;
      if (i < tl) begin
        if (int'(mode) != em[i] || int'(data) != ed[i]) begin
          if (bad_md == 0) begin am = {mode, data}; xm = em[i] * 256 + ed[i]; end
          bad_md++;
        end
        exp_s = (em[i] != 15) && (i > 0) && (em[i] == em[i-1]) && (ed[i] == ed[i-1]);
        if (strobe != exp_s) begin
          if (em[i] == 15) bad_s3++;
          else begin if (bad_s2 == 0) begin as2 = strobe; xs2 = exp_s; end bad_s2++; end
        end
        if (ready) bad_rdy++;
        if (mode == 4'd7 && prevm != 7) begin
          if (last7 >= 0 && i - last7 != BUDGET) bad_gap++;
          last7 = i;
        end
        if (i == 2) begin om2 = mode; od2 = data; end
      end else begin
        if (!ready || mode != 4'd15) bad_rdy++;
        if (last7 >= 0 && i - last7 != BUDGET) bad_gap++;
      end
      prevm = mode; prevd = data;
      if (spurious && i == tl / 2) begin
        start = 1'b1; gob_num = ~gob_num; mb_num = ~mb_num; cbp = ~cbp; dummy = ~dummy;
        ctrl_flags = ~ctrl_flags; quant = ~quant; mv_h = ~mv_h; mv_v = ~mv_v;
      end
      if (spurious && i == tl / 2 + 1) start = 1'b0;
      if (i < tl) @(negedge clk);
    end
    chk(bad_md == 0, {tag, " R5 R7 R8 event trace (mode*256+data)"}, am, xm);
    chk(bad_s2 == 0, {tag, " R2 strobe in data phase"}, as2, xs2);
    chk(bad_s3 == 0, {tag, " R3 strobe during wait"}, bad_s3, 0);
    chk(bad_ill == 0, {tag, " R1 illegal code count"}, bad_ill, 0);
    chk(bad_rdy == 0, {tag, " R11 ready only in final wait"}, bad_rdy, 0);
    if (!expect_ovf) begin
      chk(bad_gap == 0, {tag, " R9 sub-block length mismatches"}, bad_gap, 0);
      chk(overflow == 1'b0, {tag, " R10 no overflow for legal blocks"}, overflow, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mode == 4'd15, "R12 reset mode", mode, 15);
    chk(data == 8'd0, "R12 reset data", data, 0);
    chk(!strobe, "R12 reset strobe", strobe, 0);
    chk(ready, "R12 reset ready", ready, 1);
    chk(!overflow && !coef_req, "R12 reset overflow/req", {overflow, coef_req}, 0);

    // R4: all flags set, single block with one pair
    dummy = 0; ctrl_flags = 6'h3F; cbp = 6'b000001; gob_num = 8'd7; mb_num = 8'd33;
    quant = 8'd12; mv_h = 8'hF3; mv_v = 8'h05;
    for (int b = 0; b < NBLK; b++) ncoef[b] = 1;
    run_mb("flags", 0, 0);
    chk(om2 == 2 && od2 == 8'h6F, "R4 control byte", od2, 8'h6F);

    // R6: dummy macroblock skips control byte
    dummy = 1; ctrl_flags = 6'h15; cbp = 6'b010010;
    run_mb("dummy", 0, 0);
    chk(om2 == 0, "R6 group number follows initial wait", om2, 0);

    // R7: empty pattern
    dummy = 0; cbp = '0; ctrl_flags = 6'h02;
    run_mb("empty", 0, 0);
    chk(tl == 16, "R7 empty macroblock length", tl, 16);

    // R9 R13: full-budget blocks of 64 pairs
    cbp = 6'b100001;
    for (int b = 0; b < NBLK; b++) ncoef[b] = 64;
    run_mb("full", 0, 0);

    // R11: start and field changes while busy are ignored
    cbp = 6'b001100; dummy = 0; ctrl_flags = 6'h09;
    for (int b = 0; b < NBLK; b++) ncoef[b] = 3 + b;
    run_mb("busy", 1, 0);

    for (int r = 0; r < 20; r++) begin
      dummy = ($urandom_range(0, 3) == 0);
      ctrl_flags = 6'($urandom()); gob_num = 8'($urandom()); mb_num = 8'($urandom());
      quant = 8'($urandom_range(1, 31)); mv_h = 8'($urandom()); mv_v = 8'($urandom());
      cbp = 6'($urandom());
      for (int b = 0; b < NBLK; b++) ncoef[b] = $urandom_range(1, 64);
      run_mb("random", 0, 0);
    end

    // R10: 65 pairs overrun the budget; flag is sticky
    dummy = 0; cbp = 6'b000001;
    for (int b = 0; b < NBLK; b++) ncoef[b] = 65;
    run_mb("overrun", 0, 1);
    chk(overflow == 1'b1, "R10 overflow raised", overflow, 1);
    repeat (3) @(negedge clk);
    chk(overflow == 1'b1, "R10 overflow sticky", overflow, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule